// File: doc/BRIEF.md
# Serial Converter Command and Readout Front End

This block is the digital side of a 10-bit successive-approximation converter that is controlled over a four-wire serial link. A host pulls chip select low and clocks in a command byte. Leading zero bits are discarded until the first one bit arrives, and that one bit becomes the most significant bit of the command. While the byte arrives, the block publishes the channel, polarity and input-configuration fields to the analog multiplexer. It opens and closes the track/hold window at fixed points within the byte.

The two low command bits choose where the conversion clock comes from. In the first case the host's serial clock steps the bit decisions, and each decision leaves on the data output as it is made. In the other case a local divider steps the decisions against a preloaded digital sample, and the host collects the finished result later. The strobe output signals when a conversion starts and when it ends. The data and strobe pins are driven through separate enable outputs. The serial pins are oversampled on the system clock `clk`, so they may be slow and asynchronous to it.

The serial link is plain: it carries no valid/ready pair and applies no back-pressure. The host paces every bit with its serial clock, and the strobe is the only signal of progress.

Top module: `adc_ctrl_frontend`

## Requirements
- R1: After a synchronous reset with `cs_n` high, `dout_oe`, `sstrb_oe` and `track` are all 0, and the block waits for a start bit.
- R2: While `cs_n` is low, `din` is sampled on each rising `sclk` edge. Zeros before the first one have no effect, and that one is command bit 7. A falling edge of `cs_n` abandons a partly received byte.
- R3: `track` rises on the falling `sclk` edge after command bit 5 (counting the start bit as bit 1), and falls on the falling edge after bit 8.
- R4: Command bits 6:4 drive `chan_sel`. Bit 3 equal to 1 means unipolar and 0 means bipolar (`bipolar` output). Both take effect when tracking starts. Bit 2 equal to 1 means single-ended and takes effect on the falling edge after bit 6.
- R5: Command bits 1:0 equal to 11 select a serial-clocked conversion; the values 00, 01 and 10 select an internally clocked conversion. No new command is accepted while a conversion runs.
- R6: In serial-clocked mode, `sstrb` is high from the falling edge after bit 8 until the next falling edge. Result bits then appear on `dout` on the next 10 falling edges, MSB first, followed by zeros.
- R7: In serial-clocked mode, `dac_code` carries the trial code. The first trial bit is set at hold, and each falling edge keeps it when `cmp_in` is 1 or clears it otherwise, then sets the next trial bit. A comparator that returns `dac_code <= level` yields the code `level`.
- R8: In serial-clocked mode, `dout_oe` and `sstrb_oe` are 0 while `cs_n` is high. After `cs_n` falls, `sstrb` is driven low.
- R9: In internal mode, `sstrb` goes low at hold and high within `MAX_CONV_CLKS` `clk` cycles. The result equals `sample_code`.
- R10: In internal mode, the first falling `sclk` edge after `sstrb` rises puts the MSB on `dout`. The other nine bits follow, then zeros.
- R11: In internal mode, raising `cs_n` during a conversion sets `dout_oe` to 0 and keeps `sstrb_oe` at 1. `sclk` and `din` activity while `cs_n` is high is ignored, and the conversion still completes.
- R12: A unipolar result is sent as straight binary. A bipolar result is the same offset code with its MSB inverted, which is two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| sample_code | input | RES_W | Preloaded digital sample used by internal conversions |
| dac_code | output | RES_W | Trial code for the capacitive DAC |
| track | output | 1 | 1 = track, 0 = hold |
| chan_sel | output | 3 | Channel select for the multiplexer |
| bipolar | output | 1 | 1 when bipolar coding is selected |
| single_ended | output | 1 | 1 when single-ended input is selected |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Output enable for `sstrb` |

## Verification
The bench sends leading zeros, and also breaks off a byte with a chip-select cycle, before sending a real command. A design that counted from the first edge, or kept partial bits, would decode the wrong channel. It samples `track` and the field outputs after bits 4, 5, 6 and 8, so a window shifted by one edge shows up at once. In serial-clocked runs a model comparator follows `dac_code`. A wrong keep/clear rule or a strobe that lasts more or less than one period then corrupts the serial bits. In internal runs it raises chip select and toggles the serial pins with ones during the conversion. A design that aborted, captured those edges, or released the strobe would lose the result or leave `sstrb_oe` low.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  // Command framing: the start bit is bit 1 on the wire and bit 7 in the byte.
  localparam int CTRL_W   = 8;
  localparam int TRACK_AT = 5;
  localparam int SGL_AT   = 6;
  localparam logic [1:0] MODE_SERIAL_CLK = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_EXT_STRB,
    SQ_EXT_CONV,
    SQ_INT_CONV,
    SQ_INT_READ
  } seq_state_t;
endpackage

// File: rtl/adcfe_edges.sv
module adcfe_edges (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  // Serial clock edges only count while the chip is selected.
  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign sclk_fall = ~sclk & sclk_q & ~cs_n;
  assign cs_fall   = ~cs_n & cs_q;
  assign cs_rise   = cs_n & ~cs_q;
endmodule

// File: rtl/adcfe_cmd_rx.sv
module adcfe_cmd_rx
  import adcfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       din,
  output logic       active,
  output logic       track,
  output logic [2:0] chan,
  output logic       unipolar,
  output logic       single_ended,
  output logic       cmd_done,
  output logic [1:0] cmd_mode
);
  localparam int CNT_W = $clog2(CTRL_W + 1);

  logic [CTRL_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh           <= '0;
      cnt          <= '0;
      active       <= 1'b0;
      track        <= 1'b0;
      chan         <= '0;
      unipolar     <= 1'b1;
      single_ended <= 1'b1;
      cmd_done     <= 1'b0;
      cmd_mode     <= '0;
    end else begin
      cmd_done <= 1'b0;
      if (cs_fall || cs_rise) begin
        active <= 1'b0;
        cnt    <= '0;
        track  <= 1'b0;
      end else if (sclk_rise && rx_en) begin
        if (!active) begin
          if (din) begin
            active <= 1'b1;
            sh     <= {{(CTRL_W-1){1'b0}}, 1'b1};
            cnt    <= CNT_W'(1);
          end
        end else begin
          sh  <= {sh[CTRL_W-2:0], din};
          cnt <= cnt + CNT_W'(1);
        end
      end else if (sclk_fall && active) begin
        if (cnt == CNT_W'(TRACK_AT)) begin
          track    <= 1'b1;
          chan     <= sh[3:1];
          unipolar <= sh[0];
        end
        if (cnt == CNT_W'(SGL_AT)) begin
          single_ended <= sh[0];
        end
        if (cnt == CNT_W'(CTRL_W)) begin
          track    <= 1'b0;
          active   <= 1'b0;
          cmd_done <= 1'b1;
          cmd_mode <= sh[1:0];
        end
      end
    end
  end

  AST_TRACK_IN_BYTE: assert property (@(posedge clk) disable iff (rst)
    track |-> active); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CTRL_W)); // R2
endmodule

// File: rtl/adcfe_sar.sv
module adcfe_sar #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic             abort,
  input  logic             bit_in,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             done
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] mask;
  logic [RES_W-1:0] kept;

  assign kept = bit_in ? trial : (trial & ~mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      trial  <= '0;
      mask   <= '0;
      result <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy  <= 1'b0;
        mask  <= '0;
        trial <= '0;
      end else if (start) begin
        busy  <= 1'b1;
        mask  <= TOP_BIT;
        trial <= TOP_BIT;
      end else if (step && busy) begin
        trial <= kept | (mask >> 1);
        mask  <= mask >> 1;
        if (mask[0]) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= kept;
        end
      end
    end
  end

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask)); // R7
  AST_BUSY_HAS_TRIAL: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(mask) == 1)); // R7
  AST_END_MARKS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || $past(abort))); // R7
endmodule

// File: rtl/adc_ctrl_frontend.sv
module adc_ctrl_frontend
  import adcfe_pkg::*;
#(
  parameter int RES_W         = 10,
  parameter int INT_DIV       = 4,
  parameter int MAX_CONV_CLKS = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             cmp_in,
  input  logic [RES_W-1:0] sample_code,
  output logic [RES_W-1:0] dac_code,
  output logic             track,
  output logic [2:0]       chan_sel,
  output logic             bipolar,
  output logic             single_ended,
  output logic             dout,
  output logic             dout_oe,
  output logic             sstrb,
  output logic             sstrb_oe
);
  localparam int DIV_W  = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int CONV_W = $clog2(MAX_CONV_CLKS + 2);
  localparam logic [RES_W-1:0] MSB_FLIP = {1'b1, {(RES_W-1){1'b0}}};

  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic rx_en, rx_active, cmd_done, unipolar;
  logic [1:0] cmd_mode;
  logic sar_start, sar_step, sar_abort, sar_bit, sar_busy, sar_done;
  logic [RES_W-1:0] sar_result;
  logic ext_step, int_tick;

  seq_state_t       state;
  logic             mode_int, armed, sstrb_r, dout_r;
  logic [RES_W-1:0] res_sh;
  logic [DIV_W-1:0] div_cnt;
  logic [CONV_W-1:0] conv_clks;

  adcfe_edges u_edges (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  assign rx_en = (state == SQ_IDLE) || (state == SQ_INT_READ);

  adcfe_cmd_rx u_rx (
    .clk(clk), .rst(rst), .rx_en(rx_en),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .din(din),
    .active(rx_active), .track(track), .chan(chan_sel),
    .unipolar(unipolar), .single_ended(single_ended),
    .cmd_done(cmd_done), .cmd_mode(cmd_mode)
  );

  assign bipolar   = ~unipolar;
  assign ext_step  = sclk_fall && ((state == SQ_EXT_STRB) || (state == SQ_EXT_CONV));
  assign int_tick  = (state == SQ_INT_CONV) && (div_cnt == DIV_W'(INT_DIV - 1));
  assign sar_start = cmd_done;
  assign sar_step  = ext_step | int_tick;
  assign sar_abort = cs_rise && ((state == SQ_EXT_STRB) || (state == SQ_EXT_CONV));
  assign sar_bit   = (state == SQ_INT_CONV) ? (dac_code <= sample_code) : cmp_in;

  adcfe_sar #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .start(sar_start), .step(sar_step),
    .abort(sar_abort), .bit_in(sar_bit), .trial(dac_code),
    .result(sar_result), .busy(sar_busy), .done(sar_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      mode_int <= 1'b0;
      armed    <= 1'b0;
      sstrb_r  <= 1'b0;
      dout_r   <= 1'b0;
      res_sh   <= '0;
      div_cnt  <= '0;
    end else begin
      if (!cs_n) armed <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (sclk_fall) dout_r <= 1'b0;
        end
        SQ_EXT_STRB: begin
          if (cs_rise) begin
            state   <= SQ_IDLE;
            sstrb_r <= 1'b0;
          end else if (sclk_fall) begin
            sstrb_r <= 1'b0;
            dout_r  <= cmp_in ^ bipolar;
            state   <= SQ_EXT_CONV;
          end
        end
        SQ_EXT_CONV: begin
          if (cs_rise) state <= SQ_IDLE;
          else if (sclk_fall) dout_r <= cmp_in;
          else if (sar_done) state <= SQ_IDLE;
        end
        SQ_INT_CONV: begin
          div_cnt <= int_tick ? '0 : div_cnt + DIV_W'(1);
          if (sar_done) begin
            sstrb_r <= 1'b1;
            res_sh  <= sar_result ^ (bipolar ? MSB_FLIP : '0);
            state   <= SQ_INT_READ;
          end
        end
        SQ_INT_READ: begin
          if (sclk_fall) begin
            dout_r <= res_sh[RES_W-1];
            res_sh <= {res_sh[RES_W-2:0], 1'b0};
          end
        end
        default: state <= SQ_IDLE;
      endcase
      if (cmd_done) begin
        div_cnt <= '0;
        dout_r  <= 1'b0;
        if (cmd_mode == MODE_SERIAL_CLK) begin
          state    <= SQ_EXT_STRB;
          mode_int <= 1'b0;
          sstrb_r  <= 1'b1;
        end else begin
          state    <= SQ_INT_CONV;
          mode_int <= 1'b1;
          sstrb_r  <= 1'b0;
        end
      end
    end
  end

  // Internal conversion length, watched by a counter rather than a delay.
  always_ff @(posedge clk) begin
    if (rst || state != SQ_INT_CONV) conv_clks <= '0;
    else if (conv_clks != '1) conv_clks <= conv_clks + CONV_W'(1);
  end

  assign dout     = dout_r;
  assign sstrb    = sstrb_r;
  assign dout_oe  = armed & ~cs_n;
  assign sstrb_oe = armed & (mode_int | ~cs_n);

  AST_INT_BOUND: assert property (@(posedge clk) disable iff (rst)
    conv_clks < CONV_W'(MAX_CONV_CLKS)); // R9
  AST_INT_EXIT_STROBE: assert property (@(posedge clk) disable iff (rst)
    ($past(state == SQ_INT_CONV) && state != SQ_INT_CONV) |-> sstrb_r); // R11
  AST_EXT_STROBE_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    ($past(state == SQ_EXT_STRB) && $past(sclk_fall)) |-> !sstrb_r); // R6
  AST_RX_QUIET_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    sar_busy |-> !rx_active); // R5
endmodule

// File: tb/adc_ctrl_frontend_test.sv
module adc_ctrl_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 3;
  localparam int RES_W = 10;
  localparam int MAX_CONV = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic cmp_in;
  logic [RES_W-1:0] sample_code = '0;
  logic [RES_W-1:0] ext_level = '0;
  logic [RES_W-1:0] dac_code;
  logic track, bipolar, single_ended, dout, dout_oe, sstrb, sstrb_oe;
  logic [2:0] chan_sel;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model comparator: input level at or above the trial code.
  assign cmp_in = (dac_code <= ext_level);

  adc_ctrl_frontend #(.RES_W(RES_W), .INT_DIV(4), .MAX_CONV_CLKS(MAX_CONV)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cmp_in(cmp_in), .sample_code(sample_code), .dac_code(dac_code),
    .track(track), .chan_sel(chan_sel), .bipolar(bipolar),
    .single_ended(single_ended), .dout(dout), .dout_oe(dout_oe),
    .sstrb(sstrb), .sstrb_oe(sstrb_oe)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    din = b;
    wait_clks(H);
    sclk = 1'b1;
    wait_clks(H);
    sclk = 1'b0;
    wait_clks(H);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clks(2);
  endtask

  task automatic cs_high();
    cs_n = 1'b1;
    wait_clks(2);
  endtask

  function automatic logic [7:0] make_cmd(input logic [2:0] ch, input logic uni,
                                          input logic sgl, input logic [1:0] md);
    return {1'b1, ch, uni, sgl, md};
  endfunction

  // Sends a command and checks the track window and field timing (R3, R4).
  task automatic send_cmd(input logic [7:0] cmd, input int lead);
    for (int i = 0; i < lead; i++) sbit(1'b0);
    for (int i = 7; i >= 0; i--) begin
      sbit(cmd[i]);
      if (i == 4) check("R3", "track before bit 5", track, 0);
      if (i == 3) begin
        check("R3", "track after bit 5", track, 1);
        check("R4", "chan_sel", chan_sel, cmd[6:4]);
        check("R4", "bipolar", bipolar, !cmd[3]);
      end
      if (i == 2) check("R4", "single_ended", single_ended, cmd[2]);
      if (i == 0) check("R3", "hold after bit 8", track, 0);
    end
  endtask

  task automatic t_reset();
    check("R1", "dout_oe at reset", dout_oe, 0);
    check("R1", "sstrb_oe at reset", sstrb_oe, 0);
    check("R1", "track at reset", track, 0);
  endtask

  task automatic t_ext(input logic [2:0] ch, input logic uni, input logic sgl,
                       input logic [RES_W-1:0] level, input int lead);
    logic [RES_W-1:0] exp;
    ext_level = level;
    exp = level ^ (uni ? 10'd0 : 10'h200);
    cs_low();
    check("R8", "sstrb_oe after cs fall", sstrb_oe, 1);
    check("R8", "sstrb low after cs fall", sstrb, 0);
    send_cmd(make_cmd(ch, uni, sgl, 2'b11), lead);
    check("R6", "sstrb high after hold", sstrb, 1);
    check("R5", "serial mode keeps sstrb_oe", sstrb_oe, 1);
    for (int k = RES_W-1; k >= 0; k--) begin
      sbit(1'b0);
      if (k == RES_W-1) check("R6", "sstrb low after one period", sstrb, 0);
      check(uni ? "R7" : "R12", "serial dout bit", dout, exp[k]);
      check("R6", "dout_oe while selected", dout_oe, 1);
    end
    sbit(1'b0);
    check("R6", "trailing zero", dout, 0);
    cs_high();
    check("R8", "dout_oe with cs high", dout_oe, 0);
    check("R8", "sstrb_oe with cs high", sstrb_oe, 0);
  endtask

  task automatic t_int(input logic [2:0] ch, input logic uni, input logic [1:0] md,
                       input logic [RES_W-1:0] smp, input bit wiggle);
    logic [RES_W-1:0] exp;
    int waited;
    sample_code = smp;
    exp = smp ^ (uni ? 10'd0 : 10'h200);
    cs_low();
    send_cmd(make_cmd(ch, uni, 1'b1, md), 0);
    check("R9", "sstrb low at start", sstrb, 0);
    check("R5", "internal mode selected", sstrb_oe, 1);
    waited = H;
    cs_high();
    waited += 2;
    check("R11", "dout_oe with cs high", dout_oe, 0);
    check("R11", "sstrb_oe with cs high", sstrb_oe, 1);
    if (wiggle) begin
      din = 1'b1;
      for (int i = 0; i < 4; i++) begin
        sclk = 1'b1; wait_clks(1);
        sclk = 1'b0; wait_clks(1);
        waited += 2;
      end
      din = 1'b0;
    end
    while (!sstrb && waited < MAX_CONV + 20) begin
      wait_clks(1);
      waited++;
    end
    check("R9", "sstrb high within bound", (sstrb && waited <= MAX_CONV) ? 1 : 0, 1);
    check("R11", "sstrb_oe held", sstrb_oe, 1);
    cs_low();
    check("R11", "fields unchanged", chan_sel, ch);
    for (int k = RES_W-1; k >= 0; k--) begin
      sbit(1'b0);
      check(uni ? "R10" : "R12", "internal dout bit", dout, exp[k]);
    end
    sbit(1'b0);
    check("R10", "trailing zero", dout, 0);
    cs_high();
  endtask

  task automatic t_abort();
    cs_low();
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    cs_high();
    cs_low();
    for (int i = 7; i >= 3; i--) sbit(make_cmd(3'd5, 1'b1, 1'b0, 2'b11)[i]);
    check("R2", "byte restarted after cs cycle", chan_sel, 5);
    for (int i = 2; i >= 0; i--) sbit(make_cmd(3'd5, 1'b1, 1'b0, 2'b11)[i]);
    check("R6", "strobe after restarted byte", sstrb, 1);
    cs_high();
    check("R8", "sstrb_oe released", sstrb_oe, 0);
    cs_low();
    check("R8", "sstrb driven low", sstrb, 0);
    cs_high();
  endtask

  initial begin
    wait_clks(4);
    rst = 1'b0;
    wait_clks(2);
    t_reset();
    t_ext(3'd3, 1'b1, 1'b1, 10'h2A5, 0);
    t_ext(3'd6, 1'b0, 1'b0, 10'h13C, 3);
    t_ext(3'd0, 1'b1, 1'b1, 10'h3FF, 1);
    t_int(3'd2, 1'b1, 2'b01, 10'h1E7, 0);
    t_int(3'd7, 1'b0, 2'b10, 10'h2C3, 1);
    t_int(3'd4, 1'b1, 2'b00, 10'h000, 1);
    t_abort();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule